// File: doc/BRIEF.md
# Watchdog Timer with Selectable Time-Out Response

This block is a down-counting watchdog. Software sets a 24-bit start value in three byte-wide registers and then enables the timer. The counter loads that value and decrements once per clock in which the `tick` input is high. Software restarts the count by pulsing `refresh`. If no refresh arrives, the counter runs down to zero and one more tick causes a time-out.

A control bit selects what a time-out does. In interrupt mode it sets a sticky status flag, which drives the level `irq` output. The counter then wraps to all-ones and keeps running. In reset mode it pulses `rst_req` for one clock and reloads the counter. While `dbg_mode` is high, the counter is reloaded every clock, so it can never time out. When a time-out in interrupt mode happens while `stop_mode` is high, the block also pulses `wake_req` and sets a stop flag.

Software reaches the registers through a plain single-cycle register port. `reg_rdata` is combinational from `reg_addr`. No data stream passes through the block, so the port has no valid/ready handshake and no back-pressure. Every access completes in the cycle of its strobe.

Top module: `wdog_top`

## Requirements
- R1: Register map, 8-bit data, 3-bit address.
  - Address 0 is control: bit 0 enables the timer; bit 1 selects the response (0 = interrupt, 1 = reset).
  - Addresses 1, 2 and 3 hold the reload value, least significant byte at address 1.
  - Address 4 is status: bit 0 is the time-out flag; bit 1 is the stop flag.
  - Addresses 5, 6 and 7 read the live counter, least significant byte at address 5.
  - Control and reload registers read back what was written.
- R2: After reset, `irq`, `rst_req` and `wake_req` are low and all eight addresses read zero.
- R3: A control write that sets the enable bit while the timer is disabled loads the counter with the reload value at that clock edge. An all-zero reload value loads 0xFFFFFF.
- R4: While enabled, each clock with `tick` high decrements the counter by one. While disabled, the counter holds its value whatever `tick` does.
- R5: While enabled, a clock with `refresh` high reloads the counter from the reload value. This takes priority over a simultaneous `tick`.
- R6: A time-out occurs on a tick that finds the counter at zero. With reload value R, it therefore occurs on the (R+1)th tick after a load.
- R7: In interrupt mode, a time-out sets the time-out flag and moves the counter to 0xFFFFFF, from which it keeps counting down. `irq` is high exactly while the flag is set and interrupt mode is selected.
- R8: A read strobe at address 4 clears both status flags at that clock edge. The data read is the value before clearing. A time-out in the same cycle wins, and its flag is set.
- R9: In reset mode, a time-out sets the time-out flag, pulses `rst_req` high for exactly one clock, leaves `irq` low, and reloads the counter from the reload value.
- R10: While enabled and `dbg_mode` is high, the counter is reloaded every clock. No time-out, `rst_req` or `wake_req` results.
- R11: In interrupt mode, a time-out while `stop_mode` is high pulses `wake_req` for exactly one clock and sets the stop flag, in addition to the R7 effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only at status address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| tick | input | 1 | Count enable pulse |
| refresh | input | 1 | Refresh strobe, reloads the counter |
| dbg_mode | input | 1 | Debug mode, holds the counter at its reload value |
| stop_mode | input | 1 | Stop mode, a time-out also requests wake-up |
| irq | output | 1 | Interrupt request level |
| rst_req | output | 1 | One-clock system reset request |
| wake_req | output | 1 | One-clock stop-mode recovery request |

## Verification
The hardest case to reach is a time-out landing on the very clock edge of a status read. Without care the read clear would mask it. The bench gets there by loading reload value 1 and ticking once, so the counter sits at zero. It then raises `tick` and the status read strobe in the same cycle, and checks both the returned data and `irq` afterwards. The 0xFFFFFF wrap is reached from a tiny reload value, so the count never has to run through 16 million ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    WD_RESP_IRQ = 1'b0,
    WD_RESP_RST = 1'b1
  } wd_resp_e;

  typedef struct packed {
    wd_resp_e resp;
    logic     en;
  } wd_ctrl_t;

  typedef struct packed {
    logic stop;
    logic tmo;
  } wd_stat_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  wd_stat_t          stat,
  input  logic [CNT_W-1:0]  cnt,
  output wd_ctrl_t          ctrl,
  output logic [CNT_W-1:0]  reload_eff,
  output logic              en_load,
  output logic              stat_rd
);
  localparam int NB     = CNT_W / DATA_W;
  localparam int A_STAT = NB + 1;
  localparam int A_CNT0 = NB + 2;

  logic [NB-1:0][DATA_W-1:0] rld_q;
  logic [CNT_W-1:0]          rld_flat;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_rld
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rld_q[g] <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(g + 1))
          rld_q[g] <= reg_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '{resp: WD_RESP_IRQ, en: 1'b0};
    else if (reg_wr && reg_addr == '0)
      ctrl <= '{resp: wd_resp_e'(reg_wdata[1]), en: reg_wdata[0]};
  end

  assign en_load    = reg_wr && (reg_addr == '0) && reg_wdata[0] && !ctrl.en;
  assign stat_rd    = reg_rd && (reg_addr == ADDR_W'(A_STAT));
  assign rld_flat   = rld_q;
  assign reload_eff = (rld_flat == '0) ? '1 : rld_flat;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0)
      reg_rdata = {{(DATA_W-2){1'b0}}, ctrl};
    if (reg_addr == ADDR_W'(A_STAT))
      reg_rdata = {{(DATA_W-2){1'b0}}, stat};
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(b + 1))
        reg_rdata = rld_q[b];
      if (reg_addr == ADDR_W'(A_CNT0 + b))
        reg_rdata = cnt[b*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
  import wdog_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wd_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] reload,
  input  logic             en_load,
  input  logic             tick,
  input  logic             refresh,
  input  logic             dbg_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tmo_evt
);
  logic reload_now;

  assign reload_now = en_load || (ctrl.en && (refresh || dbg_mode));
  assign tmo_evt    = ctrl.en && !reload_now && tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (reload_now)
      cnt_q <= reload;
    else if (tmo_evt)
      cnt_q <= (ctrl.resp == WD_RESP_IRQ) ? '1 : reload;
    else if (ctrl.en && tick)
      cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tmo_evt,
  input  wd_resp_e resp,
  input  logic     stop_mode,
  input  logic     stat_rd,
  output wd_stat_t stat,
  output logic     irq,
  output logic     rst_req,
  output logic     wake_req
);
  logic irq_mode;

  assign irq_mode = (resp == WD_RESP_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat     <= '0;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      rst_req  <= tmo_evt && !irq_mode;
      wake_req <= tmo_evt && irq_mode && stop_mode;
      if (tmo_evt) begin
        stat.tmo <= 1'b1;
        if (irq_mode && stop_mode)
          stat.stop <= 1'b1;
      end else if (stat_rd) begin
        stat <= '0;
      end
    end
  end

  assign irq = stat.tmo && irq_mode;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter  int CNT_W  = 24,
  parameter  int DATA_W = 8,
  localparam int NB     = CNT_W / DATA_W,
  localparam int ADDR_W = $clog2(2 * NB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick,
  input  logic              refresh,
  input  logic              dbg_mode,
  input  logic              stop_mode,
  output logic              irq,
  output logic              rst_req,
  output logic              wake_req
);
  wd_ctrl_t         ctrl;
  wd_stat_t         stat;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_eff;
  logic             en_load;
  logic             stat_rd;
  logic             tmo_evt;
  logic             ctrl_en;
  logic             ctrl_rst;

  assign ctrl_en  = ctrl.en;
  assign ctrl_rst = (ctrl.resp == WD_RESP_RST);

  wdog_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat(stat), .cnt(cnt_q), .ctrl(ctrl), .reload_eff(reload_eff),
    .en_load(en_load), .stat_rd(stat_rd)
  );

  wdog_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .reload(reload_eff),
    .en_load(en_load), .tick(tick), .refresh(refresh), .dbg_mode(dbg_mode),
    .cnt_q(cnt_q), .tmo_evt(tmo_evt)
  );

  wdog_resp resp_i (
    .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .resp(ctrl.resp),
    .stop_mode(stop_mode), .stat_rd(stat_rd), .stat(stat),
    .irq(irq), .rst_req(rst_req), .wake_req(wake_req)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             rst_req,
  input logic             wake_req,
  input logic             tick,
  input logic             refresh,
  input logic             dbg_mode,
  input logic             en,
  input logic             rst_mode,
  input logic             en_load,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req); // R11
  AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !rst_mode); // R7
  AST_REFRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && refresh) |=> (cnt == $past(reload))); // R5
  AST_DEBUG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dbg_mode) |=> (!rst_req && !wake_req && cnt == $past(reload))); // R10
  AST_WRAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !refresh && !dbg_mode && !rst_mode && cnt == '0) |=> (cnt == '1)); // R7
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !refresh && !dbg_mode && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !en_load) |=> $stable(cnt)); // R4
endmodule

bind wdog_top wdog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rst_req(rst_req), .wake_req(wake_req),
  .tick(tick), .refresh(refresh), .dbg_mode(dbg_mode), .en(ctrl_en),
  .rst_mode(ctrl_rst), .en_load(en_load), .cnt(cnt_q), .reload(reload_eff)
);

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick = 1'b0, refresh = 1'b0, dbg_mode = 1'b0, stop_mode = 1'b0;
  logic       irq, rst_req, wake_req;

  int n_chk = 0, n_err = 0;
  int rst_seen = 0, wake_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick(tick), .refresh(refresh), .dbg_mode(dbg_mode), .stop_mode(stop_mode),
    .irq(irq), .rst_req(rst_req), .wake_req(wake_req)
  );

  always @(negedge clk) begin
    if (rst_req) rst_seen++;
    if (wake_req) wake_seen++;
  end

  typedef struct packed {
    logic [23:0] rld;
    logic [7:0]  nt;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'd3,  8'd3,  1'b0},
    '{24'd3,  8'd4,  1'b1},
    '{24'd16, 8'd16, 1'b0},
    '{24'd16, 8'd17, 1'b1},
    '{24'd1,  8'd2,  1'b1},
    '{24'd0,  8'd2,  1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_cnt(output logic [23:0] c);
    logic [7:0] b0, b1, b2;
    rd_reg(3'd5, b0); rd_reg(3'd6, b1); rd_reg(3'd7, b2);
    c = {b2, b1, b0};
  endtask

  task automatic set_reload(logic [23:0] v);
    wr_reg(3'd1, v[7:0]); wr_reg(3'd2, v[15:8]); wr_reg(3'd3, v[23:16]);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  d;
    logic [23:0] c;
    int          base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 irq", irq, 0); chk("R2 rst_req", rst_req, 0); chk("R2 wake_req", wake_req, 0);
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), d);
      chk("R2 reg zero", d, 0);
    end

    // R1 readback of control and reload bytes
    set_reload(24'h563412);
    rd_reg(3'd1, d); chk("R1 reload lo", d, 8'h12);
    rd_reg(3'd3, d); chk("R1 reload hi", d, 8'h56);
    wr_reg(3'd0, 8'h02); rd_reg(3'd0, d); chk("R1 ctrl", d, 8'h02);
    wr_reg(3'd0, 8'h00);

    // table of time-out vectors, R6
    foreach (VECS[k]) begin
      wr_reg(3'd0, 8'h00);
      set_reload(VECS[k].rld);
      wr_reg(3'd0, 8'h01);
      tick_n(int'(VECS[k].nt));
      chk("R6 irq after ticks", irq, VECS[k].exp);
      rd_reg(3'd4, d);
      chk("R6 status", d, {7'b0, VECS[k].exp});
      chk("R8 irq after read", irq, 0);
    end

    // R3 zero reload loads all ones
    wr_reg(3'd0, 8'h00); set_reload(24'h0); wr_reg(3'd0, 8'h01);
    rd_cnt(c); chk("R3 zero reload", c, 24'hFFFFFF);

    // R4 decrement and hold while disabled
    wr_reg(3'd0, 8'h00); set_reload(24'd5); wr_reg(3'd0, 8'h01);
    rd_cnt(c); chk("R3 load", c, 24'd5);
    tick_n(2); rd_cnt(c); chk("R4 decrement", c, 24'd3);
    wr_reg(3'd0, 8'h00); tick_n(3); rd_cnt(c); chk("R4 hold disabled", c, 24'd3);

    // R5 refresh beats tick
    wr_reg(3'd0, 8'h01); tick_n(3); rd_cnt(c); chk("R4 count", c, 24'd2);
    @(negedge clk); tick = 1'b1; refresh = 1'b1;
    @(negedge clk); tick = 1'b0; refresh = 1'b0;
    rd_cnt(c); chk("R5 refresh priority", c, 24'd5);

    // R7 wrap to all ones and keep counting
    wr_reg(3'd0, 8'h00); set_reload(24'd2); wr_reg(3'd0, 8'h01);
    tick_n(3); chk("R7 irq", irq, 1);
    rd_cnt(c); chk("R7 wrap", c, 24'hFFFFFF);
    tick_n(1); rd_cnt(c); chk("R7 continue", c, 24'hFFFFFE);
    rd_reg(3'd4, d); chk("R8 status value", d, 8'h01); chk("R8 cleared", irq, 0);

    // R8 time-out coinciding with status read
    wr_reg(3'd0, 8'h00); set_reload(24'd1); wr_reg(3'd0, 8'h01);
    tick_n(1);
    @(negedge clk); tick = 1'b1; reg_addr = 3'd4; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); tick = 1'b0; reg_rd = 1'b0;
    chk("R8 read before set", d, 8'h00); chk("R8 set wins", irq, 1);
    rd_reg(3'd4, d);

    // R9 reset response
    wr_reg(3'd0, 8'h00); set_reload(24'd1); wr_reg(3'd0, 8'h03);
    base = rst_seen;
    tick_n(2); repeat (3) @(negedge clk);
    chk("R9 one pulse", rst_seen - base, 1);
    chk("R9 irq low", irq, 0);
    rd_cnt(c); chk("R9 reload", c, 24'd1);
    rd_reg(3'd4, d); chk("R9 status", d, 8'h01);

    // R10 debug holds counter
    wr_reg(3'd0, 8'h00); set_reload(24'd2); wr_reg(3'd0, 8'h01);
    base = rst_seen;
    @(negedge clk); dbg_mode = 1'b1;
    tick_n(6);
    chk("R10 no irq", irq, 0);
    rd_cnt(c); chk("R10 counter", c, 24'd2);
    @(negedge clk); dbg_mode = 1'b0;

    // R11 stop-mode time-out
    stop_mode = 1'b1; base = wake_seen;
    tick_n(3); repeat (2) @(negedge clk);
    chk("R11 wake pulse", wake_seen - base, 1);
    chk("R11 irq", irq, 1);
    rd_reg(3'd4, d); chk("R11 status", d, 8'h03);
    stop_mode = 1'b0;

    finish_run();
  end
endmodule